// File: doc/BRIEF.md
# Direct-Mapped Data Cache with Selectable Write Policy

This block is a direct-mapped data cache placed between one processor port and a word-addressed main memory. The processor issues single-word reads and writes with a valid/ready handshake. It holds `cpu_valid` and the request fields steady until `cpu_ready` is high for one cycle, which completes the request. Each cache line holds a valid flag, a dirty flag, a tag and a block of 16 words. A block is 64 bytes.

The `wt_mode` input picks the write policy for each request. In write-back mode (`wt_mode` = 0), writes stay in the cache and the line is marked dirty. A write miss allocates the line. In write-through mode (`wt_mode` = 1), every write goes to memory as one beat, and a write miss does not allocate.

On a miss the cache first writes a dirty victim back, one word per beat. It then refills the whole line, one word per beat. The memory side uses a request/ready handshake.

Top module: `dm_wb_cache`

## Requirements
- R1: A word address is split into three fields. Bits [3:0] are the word offset within the line. The next log2(LINES) bits are the line index. The remaining high bits are the tag. With 8 lines, block number 21 (word address 0x157) lands in line 5 with tag 2, so it evicts another block that shares index 5.
- R2: Reset clears every valid and dirty flag. After reset, a read of any address is a miss: it makes 16 read beats and no write beats.
- R3: A read that hits (valid line, tag equal) raises `cpu_ready` in the same cycle that `cpu_valid` is seen, with the addressed word on `cpu_rdata`. It makes no memory traffic, and `cpu_ready` is never high while `cpu_valid` is low.
- R4: A miss whose line is invalid or clean makes 16 read beats. The first beat is at the line-aligned base of the requested block, and each later beat is at the next word address. `cpu_ready` stays low until the fill ends, and the read then returns the requested word.
- R5: In write-back mode, a write hit updates only the cached word and marks the line dirty. It makes no memory traffic.
- R6: When a miss finds its line valid and dirty, the cache first writes the 16 words of the old block back to the old block's own addresses. Only then does it fill the new block. This holds in either mode.
- R7: In write-back mode, a write miss fills the line, then merges the written word, and leaves the line dirty.
- R8: In write-through mode, every write makes exactly one memory write beat to the request address. `cpu_ready` rises together with the accepted beat. On a hit the cached word is updated and the dirty flag is left unchanged.
- R9: In write-through mode, a write miss does not allocate a line. A later read of that address is a miss and returns the written value from memory.
- R10: While `mem_req` is high and `mem_ready` is low, `mem_req`, `mem_we` and `mem_addr` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| wt_mode | input | 1 | 1 selects write-through, 0 selects write-back |
| cpu_valid | input | 1 | Processor request present |
| cpu_we | input | 1 | 1 for a write request |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid when cpu_ready is high on a read |
| mem_req | output | 1 | Memory beat requested |
| mem_we | output | 1 | 1 for a memory write beat |
| mem_addr | output | ADDR_W | Memory word address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, valid when mem_ready is high |
| mem_ready | input | 1 | Memory accepts or returns this beat |

## Verification
The hardest case to reach is a dirty victim that is evicted by a read issued in write-through mode. The line must first be dirtied by a write-back allocation. It must then receive a write-through hit, which must leave it dirty. Finally another tag must arrive at the same index. The stimulus table builds this chain on line 3, then checks for 16 write beats before the fill. It also checks that the memory holds both the allocated word and the write-through word afterwards. The memory model drops `mem_ready` on a fixed rhythm, so every burst is stretched by stalls, and the data and beat counts must still come out exact.

// File: rtl/dmc_pkg.sv
// Shared types for the direct-mapped cache.
package dmc_pkg;
    // Controller states: lookup, victim write-back, line fill, single write-through beat.
    typedef enum logic [1:0] {
        ST_LOOKUP = 2'd0,
        ST_EVICT  = 2'd1,
        ST_FILL   = 2'd2,
        ST_WTWR   = 2'd3
    } ctl_state_t;
endpackage

// File: rtl/dmc_tag_store.sv
// Per-line valid, dirty and tag flags with a lookup at one index.
// Assumes the index is held steady by the controller for a whole request.
module dmc_tag_store #(
    parameter int LINES = 8,
    parameter int IDX_W = 3,
    parameter int TAG_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic [TAG_W-1:0] req_tag,
    input  logic             fill_done,
    input  logic             mark_dirty,
    output logic             lk_valid,
    output logic             lk_dirty,
    output logic             lk_hit,
    output logic [TAG_W-1:0] victim_tag
);
    logic [LINES-1:0] valid_vec;
    logic [LINES-1:0] dirty_vec;
    logic [TAG_W-1:0] tag_arr [LINES];

    for (genvar g = 0; g < LINES; g++) begin : g_line
        logic             v_q;
        logic             d_q;
        logic [TAG_W-1:0] t_q;

        // Update this line's flags on a completed fill or a write-back hit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                v_q <= 1'b0;
                d_q <= 1'b0;
                t_q <= '0;
            end else if (idx == IDX_W'(g)) begin
                if (fill_done) begin
                    v_q <= 1'b1;
                    d_q <= 1'b0;
                    t_q <= req_tag;
                end else if (mark_dirty) begin
                    d_q <= 1'b1;
                end
            end
        end

        assign valid_vec[g] = v_q;
        assign dirty_vec[g] = d_q;
        assign tag_arr[g]   = t_q;
    end

    // Lookup of the indexed line.
    always_comb begin
        lk_valid   = valid_vec[idx];
        lk_dirty   = dirty_vec[idx];
        victim_tag = tag_arr[idx];
        lk_hit     = lk_valid && (victim_tag == req_tag);
    end
endmodule

// File: rtl/dmc_data_store.sv
// Word array of the cache: one write port and two read ports.
// Port A serves the processor word, port B serves the victim word.
module dmc_data_store #(
    parameter int LINES  = 8,
    parameter int WORDS  = 16,
    parameter int DATA_W = 32,
    parameter int IDX_W  = 3,
    parameter int OFF_W  = 4
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  idx,
    input  logic [OFF_W-1:0]  wr_off,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [OFF_W-1:0]  a_off,
    output logic [DATA_W-1:0] a_data,
    input  logic [OFF_W-1:0]  b_off,
    output logic [DATA_W-1:0] b_data
);
    logic [DATA_W-1:0] words_q [LINES][WORDS];

    // Store one word per cycle.
    always_ff @(posedge clk) begin
        if (wr_en) words_q[idx][wr_off] <= wr_data;
    end

    // Combinational read of both ports.
    always_comb begin
        a_data = words_q[idx][a_off];
        b_data = words_q[idx][b_off];
    end
endmodule

// File: rtl/dmc_ctrl.sv
// Request sequencer: decides hit, victim write-back, fill or write-through beat,
// and counts burst beats. Assumes the processor holds its request until cpu_ready.
module dmc_ctrl
    import dmc_pkg::*;
#(
    parameter int WORDS = 16,
    parameter int OFF_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_valid,
    input  logic             cpu_we,
    input  logic             wt_mode,
    input  logic             lk_hit,
    input  logic             lk_valid,
    input  logic             lk_dirty,
    input  logic             mem_ready,
    output ctl_state_t       st,
    output logic [OFF_W-1:0] beat,
    output logic             in_burst,
    output logic             cpu_ready,
    output logic             mem_req,
    output logic             mem_we,
    output logic             dwr_en,
    output logic             dwr_fill,
    output logic             fill_done,
    output logic             mark_dirty
);
    localparam logic [OFF_W-1:0] LAST = OFF_W'(WORDS - 1);

    ctl_state_t nxt;
    logic       last;

    assign last     = (beat == LAST);
    assign in_burst = (st == ST_EVICT) || (st == ST_FILL);

    // State and beat counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st   <= ST_LOOKUP;
            beat <= '0;
        end else begin
            st <= nxt;
            if (in_burst && mem_ready) beat <= beat + 1'b1;
        end
    end

    // Next state and control strobes.
    always_comb begin
        nxt        = st;
        cpu_ready  = 1'b0;
        mem_req    = 1'b0;
        mem_we     = 1'b0;
        dwr_en     = 1'b0;
        dwr_fill   = 1'b0;
        fill_done  = 1'b0;
        mark_dirty = 1'b0;
        case (st)
            ST_LOOKUP: begin
                if (cpu_valid) begin
                    if (cpu_we && wt_mode) begin
                        nxt = ST_WTWR;
                    end else if (lk_hit) begin
                        cpu_ready = 1'b1;
                        if (cpu_we) begin
                            dwr_en     = 1'b1;
                            mark_dirty = 1'b1;
                        end
                    end else if (lk_valid && lk_dirty) begin
                        nxt = ST_EVICT;
                    end else begin
                        nxt = ST_FILL;
                    end
                end
            end
            ST_WTWR: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready) begin
                    cpu_ready = 1'b1;
                    dwr_en    = lk_hit;
                    nxt       = ST_LOOKUP;
                end
            end
            ST_EVICT: begin
                mem_req = 1'b1;
                mem_we  = 1'b1;
                if (mem_ready && last) nxt = ST_FILL;
            end
            ST_FILL: begin
                mem_req = 1'b1;
                if (mem_ready) begin
                    dwr_en   = 1'b1;
                    dwr_fill = 1'b1;
                    if (last) begin
                        fill_done = 1'b1;
                        nxt       = ST_LOOKUP;
                    end
                end
            end
            default: nxt = ST_LOOKUP;
        endcase
    end
endmodule

// File: rtl/dm_wb_cache.sv
// Direct-mapped cache top: splits the address, ties together the tag store,
// the data store and the sequencer, and forms the memory beat address and data.
// Assumes a word-addressed memory and a processor that holds each request until ready.
module dm_wb_cache
    import dmc_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int LINES  = 8,
    parameter int WORDS  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wt_mode,
    input  logic              cpu_valid,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_ready,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              mem_req,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    input  logic              mem_ready
);
    localparam int OFF_W = $clog2(WORDS);
    localparam int IDX_W = $clog2(LINES);
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W;

    logic [OFF_W-1:0]  off;
    logic [IDX_W-1:0]  idx;
    logic [TAG_W-1:0]  tag;
    logic [TAG_W-1:0]  victim_tag;
    logic              lk_valid, lk_dirty, lk_hit;
    ctl_state_t        st;
    logic [OFF_W-1:0]  beat;
    logic              in_burst;
    logic              dwr_en, dwr_fill, fill_done, mark_dirty;
    logic [OFF_W-1:0]  wr_off;
    logic [DATA_W-1:0] wr_data;
    logic [DATA_W-1:0] evict_word;

    assign {tag, idx, off} = cpu_addr;

    dmc_tag_store #(.LINES(LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) u_tags (
        .clk        (clk),
        .rst_n      (rst_n),
        .idx        (idx),
        .req_tag    (tag),
        .fill_done  (fill_done),
        .mark_dirty (mark_dirty),
        .lk_valid   (lk_valid),
        .lk_dirty   (lk_dirty),
        .lk_hit     (lk_hit),
        .victim_tag (victim_tag)
    );

    dmc_ctrl #(.WORDS(WORDS), .OFF_W(OFF_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpu_valid  (cpu_valid),
        .cpu_we     (cpu_we),
        .wt_mode    (wt_mode),
        .lk_hit     (lk_hit),
        .lk_valid   (lk_valid),
        .lk_dirty   (lk_dirty),
        .mem_ready  (mem_ready),
        .st         (st),
        .beat       (beat),
        .in_burst   (in_burst),
        .cpu_ready  (cpu_ready),
        .mem_req    (mem_req),
        .mem_we     (mem_we),
        .dwr_en     (dwr_en),
        .dwr_fill   (dwr_fill),
        .fill_done  (fill_done),
        .mark_dirty (mark_dirty)
    );

    // Write source: memory word during a fill, processor word otherwise.
    assign wr_off  = dwr_fill ? beat : off;
    assign wr_data = dwr_fill ? mem_rdata : cpu_wdata;

    dmc_data_store #(
        .LINES(LINES), .WORDS(WORDS), .DATA_W(DATA_W), .IDX_W(IDX_W), .OFF_W(OFF_W)
    ) u_data (
        .clk     (clk),
        .wr_en   (dwr_en),
        .idx     (idx),
        .wr_off  (wr_off),
        .wr_data (wr_data),
        .a_off   (off),
        .a_data  (cpu_rdata),
        .b_off   (beat),
        .b_data  (evict_word)
    );

    // Memory beat address and write data per sequencer state.
    always_comb begin
        mem_wdata = cpu_wdata;
        case (st)
            ST_EVICT: begin
                mem_addr  = {victim_tag, idx, beat};
                mem_wdata = evict_word;
            end
            ST_FILL: mem_addr = {tag, idx, beat};
            default: mem_addr = cpu_addr;
        endcase
    end
endmodule

// File: rtl/dm_wb_cache_chk.sv
// Protocol checker for the cache, attached to every instance by bind.
module dm_wb_cache_chk #(
    parameter int ADDR_W = 12,
    parameter int OFF_W  = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wt_mode,
    input logic              cpu_valid,
    input logic              cpu_we,
    input logic              cpu_ready,
    input logic              mem_req,
    input logic              mem_we,
    input logic              mem_ready,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              in_burst
);
    // R3
    ready_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ready |-> cpu_valid);

    // R4
    burst_ready_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_burst |-> !cpu_ready);

    // R4
    burst_aligned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_burst) |-> (mem_addr[OFF_W-1:0] == '0));

    // R4
    burst_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_burst && mem_ready && (mem_addr[OFF_W-1:0] != '1))
        |=> (in_burst && (mem_addr == ADDR_W'($past(mem_addr) + 1'b1))));

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

    // R5
    wb_hit_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we && !wt_mode) |-> !mem_req);

    // R8
    wt_write_mem_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_ready && cpu_we && wt_mode) |-> (mem_req && mem_we && mem_ready));
endmodule

bind dm_wb_cache dm_wb_cache_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wt_mode   (wt_mode),
    .cpu_valid (cpu_valid),
    .cpu_we    (cpu_we),
    .cpu_ready (cpu_ready),
    .mem_req   (mem_req),
    .mem_we    (mem_we),
    .mem_ready (mem_ready),
    .mem_addr  (mem_addr),
    .in_burst  (in_burst)
);

// File: tb/sim_dm_wb_cache.sv
`timescale 1ns/1ps
module sim_dm_wb_cache;
    localparam int AW = 12;
    localparam int DW = 32;
    localparam int MW = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wt_mode = 1'b0;
    logic          cpu_valid = 1'b0;
    logic          cpu_we = 1'b0;
    logic [AW-1:0] cpu_addr = '0;
    logic [DW-1:0] cpu_wdata = '0;
    logic          cpu_ready;
    logic [DW-1:0] cpu_rdata;
    logic          mem_req, mem_we;
    logic [AW-1:0] mem_addr;
    logic [DW-1:0] mem_wdata;
    logic [DW-1:0] mem_rdata;
    logic          mem_ready = 1'b0;

    int tests = 0;
    int fails = 0;
    int tick = 0;
    int wr_beats = 0;
    int rd_beats = 0;
    int order_err = 0;

    logic [DW-1:0] mm    [MW];
    logic [DW-1:0] ref_m [MW];

    always #4 clk = ~clk;

    dm_wb_cache #(.ADDR_W(AW), .DATA_W(DW), .LINES(8), .WORDS(16)) u0 (
        .clk(clk), .rst_n(rst_n), .wt_mode(wt_mode),
        .cpu_valid(cpu_valid), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .mem_ready(mem_ready)
    );

    assign mem_rdata = mm[mem_addr];

    // Memory model: stalls one cycle in four, records beats at the falling edge.
    always @(negedge clk) begin
        tick = tick + 1;
        mem_ready = ((tick % 4) != 2);
        if (mem_ready && mem_req) begin
            if (mem_we) begin
                mm[mem_addr] = mem_wdata;
                wr_beats = wr_beats + 1;
            end else begin
                if (mem_addr[3:0] != 4'(rd_beats % 16)) order_err = order_err + 1;
                rd_beats = rd_beats + 1;
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        tests = tests + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One processor request; returns read data and the cycles until ready.
    task automatic access(input logic we, input logic wt, input logic [AW-1:0] a,
                          input logic [DW-1:0] d, output logic [DW-1:0] rd, output int cyc);
        bit done = 0;
        wr_beats = 0; rd_beats = 0; order_err = 0;
        cpu_valid = 1'b1; cpu_we = we; wt_mode = wt; cpu_addr = a; cpu_wdata = d;
        cyc = 0;
        rd = '0;
        while (!done) begin
            #1;
            cyc = cyc + 1;
            if (cpu_ready) begin
                rd = cpu_rdata;
                done = 1;
            end
            @(negedge clk);
            if (cyc > 2000) done = 1;
        end
        cpu_valid = 1'b0; cpu_we = 1'b0;
        if (we) ref_m[a] = d;
    endtask

    typedef struct packed {
        logic          we;
        logic          wt;
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic          hit;
        logic [4:0]    wb;
        logic [4:0]    rb;
        logic [3:0]    rq;
    } vec_t;

    // Address layout: tag [11:7], index [6:4], offset [3:0].
    localparam int NV = 19;
    localparam vec_t VEC [NV] = '{
        '{1'b0,1'b0,12'h053,32'h0,       1'b0,5'd0, 5'd16,4'd4},  // R4 cold miss, line 5
        '{1'b0,1'b0,12'h059,32'h0,       1'b1,5'd0, 5'd0, 4'd3},  // R3 read hit
        '{1'b1,1'b0,12'h059,32'hDEAD0001,1'b1,5'd0, 5'd0, 4'd5},  // R5 write-back hit
        '{1'b0,1'b0,12'h059,32'h0,       1'b1,5'd0, 5'd0, 4'd5},  // R5 merged word
        '{1'b0,1'b0,12'h0D0,32'h0,       1'b0,5'd16,5'd16,4'd6},  // R6 dirty victim
        '{1'b0,1'b0,12'h059,32'h0,       1'b0,5'd0, 5'd16,4'd6},  // R6 value came back
        '{1'b1,1'b0,12'h134,32'hCAFE0002,1'b0,5'd0, 5'd16,4'd7},  // R7 write miss allocate
        '{1'b0,1'b0,12'h134,32'h0,       1'b1,5'd0, 5'd0, 4'd7},  // R7 merged after fill
        '{1'b1,1'b1,12'h135,32'hBEEF0003,1'b0,5'd1, 5'd0, 4'd8},  // R8 write-through hit
        '{1'b0,1'b0,12'h135,32'h0,       1'b1,5'd0, 5'd0, 4'd8},  // R8 cache updated
        '{1'b1,1'b1,12'h260,32'h12340004,1'b0,5'd1, 5'd0, 4'd9},  // R9 write-through miss
        '{1'b0,1'b0,12'h260,32'h0,       1'b0,5'd0, 5'd16,4'd9},  // R9 no allocation
        '{1'b0,1'b1,12'h1B0,32'h0,       1'b0,5'd16,5'd16,4'd6},  // R6 dirty evict in WT mode
        '{1'b0,1'b0,12'h134,32'h0,       1'b0,5'd0, 5'd16,4'd6},  // R6 write-back data
        '{1'b1,1'b1,12'h134,32'h55550005,1'b0,5'd1, 5'd0, 4'd8},  // R8 hit on clean line
        '{1'b0,1'b0,12'h2B0,32'h0,       1'b0,5'd0, 5'd16,4'd8},  // R8 line stayed clean
        '{1'b0,1'b0,12'h157,32'h0,       1'b0,5'd0, 5'd16,4'd1},  // R1 block 21 -> line 5
        '{1'b0,1'b0,12'h157,32'h0,       1'b1,5'd0, 5'd0, 4'd1},  // R1 tag 2 now resident
        '{1'b0,1'b0,12'h059,32'h0,       1'b0,5'd0, 5'd16,4'd1}   // R1 same index, tag 0
    };

    initial begin
        #(8 * 150000);
        fails = fails + 1;
        tests = tests + 1;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        logic [DW-1:0] rd;
        int            cyc;
        string         tag;
        for (int i = 0; i < MW; i++) begin
            mm[i]    = (i * 32'h0100_0193) ^ 32'hA5A5_0000;
            ref_m[i] = (i * 32'h0100_0193) ^ 32'hA5A5_0000;
        end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(cpu_ready == 1'b0, "R3 idle ready", 32'(cpu_ready), 32'h0);
        chk(mem_req == 1'b0, "R2 reset mem_req", 32'(mem_req), 32'h0);
        @(negedge clk);

        for (int v = 0; v < NV; v++) begin
            access(VEC[v].we, VEC[v].wt, VEC[v].a, VEC[v].d, rd, cyc);
            tag = $sformatf("R%0d vec%0d", VEC[v].rq, v);
            if (!VEC[v].we)
                chk(rd == ref_m[VEC[v].a], {tag, " rdata"}, rd, ref_m[VEC[v].a]);
            if (VEC[v].hit)
                chk(cyc == 1, {tag, " hit latency"}, 32'(cyc), 32'd1);
            else
                chk(cyc > 1, {tag, " miss latency"}, 32'(cyc), 32'd2);
            chk(wr_beats == int'(VEC[v].wb), {tag, " write beats"}, 32'(wr_beats), 32'(VEC[v].wb));
            chk(rd_beats == int'(VEC[v].rb), {tag, " read beats"}, 32'(rd_beats), 32'(VEC[v].rb));
            chk(order_err == 0, {tag, " R4 fill order"}, 32'(order_err), 32'h0);
        end

        // R6 and R10: memory contents after stalled write-back bursts
        chk(mm[12'h059] == 32'hDEAD0001, "R6 mem 059", mm[12'h059], 32'hDEAD0001);
        chk(mm[12'h135] == 32'hBEEF0003, "R10 mem 135", mm[12'h135], 32'hBEEF0003);
        // R8 write-through of the last value
        chk(mm[12'h134] == 32'h55550005, "R8 mem 134", mm[12'h134], 32'h55550005);
        chk(mm[12'h260] == 32'h12340004, "R9 mem 260", mm[12'h260], 32'h12340004);

        // R2: reset drops a resident line
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 1'b0, 12'h157, 32'h0, rd, cyc);
        chk(rd_beats == 16, "R2 read after reset misses", 32'(rd_beats), 32'd16);
        chk(rd == ref_m[12'h157], "R2 rdata", rd, ref_m[12'h157]);

        // R2: reset drops the dirty flag
        access(1'b1, 1'b0, 12'h157, 32'h77770007, rd, cyc);
        chk(cyc == 1 && wr_beats == 0, "R5 wb hit before reset", 32'(cyc), 32'd1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b0, 1'b0, 12'h1D0, 32'h0, rd, cyc);
        chk(wr_beats == 0, "R2 dirty cleared", 32'(wr_beats), 32'd0);
        chk(rd_beats == 16, "R2 fill after reset", 32'(rd_beats), 32'd16);
        #1;
        chk(cpu_ready == 1'b0, "R3 ready low without valid", 32'(cpu_ready), 32'h0);

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule